// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer with Lock Detection

This block takes a serial stream arriving one bit per cycle on a bit-rate clock that is already phase-aligned, and turns it back into 10-bit words. Each 12-bit frame on the line carries a leading clock bit of 1, ten data bits sent least-significant first, and a trailing clock bit of 0. The block keeps a candidate frame alignment and checks the two clock bits at that alignment. It uses the result both to acquire lock and to decide when lock is gone.

Lock can be reached quickly when the far end sends sync frames (six ones then six zeros). It can also be reached more slowly by scanning ordinary data for an alignment whose clock bits stay valid. While unlocked, every output is held high. While locked, the lock indicator is low and each completed frame yields one word together with a one-cycle strobe. Two bad frames in a row drop lock and send the block back to searching, from which it can relock by either method.

Top module: `emb_clk_deser`

## Requirements
- R1: A frame is 12 bits in time order: clock bit 1, data bits d0 to d9, clock bit 0. While locked, word_out bit i equals d_i, and word_stb is high for exactly one cycle per frame. Both are registered at the clock edge that samples the frame's last bit, so strobes are 12 cycles apart while lock holds.
- R2: lock_n is active low. It is high from reset until lock is first acquired.
- R3: Whenever lock_n is high, word_out is all ones and word_stb is high.
- R4: Two sync frames (bit pattern 111111000000, data word 0x01F) at the same offset, 12 bits apart, grant lock at any alignment. lock_n falls at the edge that samples the second sync frame's last bit. That frame is not delivered, so word_stb is low in that cycle. One sync frame alone does not lock.
- R5: In random-data search, a candidate alignment is accepted after 16 consecutive frames with valid clock bits. After reset the first candidate frame ends at the 12th sampled bit. lock_n stays high after 15 valid frames and falls at the edge that samples the 16th frame's last bit.
- R6: During search, an invalid frame restarts the valid-frame count and moves the candidate one bit earlier, so the next candidate frame ends 11 bits later. From any starting offset the search reaches the true alignment.
- R7: While locked, a single frame with a bad clock bit does not drop lock, and its data word is still delivered with a strobe.
- R8: While locked, a second consecutive bad frame raises lock_n at the edge that samples its last bit. That frame is not delivered, and the outputs return to all high.
- R9: After lock is lost, the block relocks from either sync frames or random data, with the candidate alignment continuing from the one in use when lock was lost.
- R10: A synchronous active-low reset returns the block to search with lock_n, word_stb and every word_out bit high from the first edge at which reset is sampled.
- R11: A valid frame between two bad frames clears the bad-frame history, so bad, good, bad keeps lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| word_out | output | 10 | Recovered data word, all ones while unlocked |
| word_stb | output | 1 | One-cycle word strobe while locked, held high while unlocked |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
Every result is registered at the rising edge that samples the last bit of a frame: the delivered word and its strobe, lock_n falling on the second sync frame or on the 16th valid frame, and lock_n rising on the second bad frame. None lags by more than that edge. The frame driver returns at the falling edge right after that last-bit edge, and the lock checks are made there. The scoreboard monitor samples a quarter period after every rising edge and pops one expected word per strobe. The driver decides whether a frame will be delivered from lock_n at the moment the frame's first bit goes out. For the bad-frame and lock-granting frames it is told explicitly instead.

// File: rtl/ecd_pkg.sv
// Package ecd_pkg
// Shared constants and types for the embedded-clock deserializer.
// Assumes exactly two clock bits per frame, one on each side of the data.
package ecd_pkg;
    localparam int CLK_BITS = 2;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/ecd_window.sv
// Module ecd_window
// Keeps the previous FRAME_W-1 serial bits and forms a full-frame window
// together with the bit arriving now. From that window it derives the
// data word (least-significant bit sent first), the clock-bit check and
// the sync-pattern match. Assumes the oldest bit sits at the window's top.
module ecd_window #(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + ecd_pkg::CLK_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [DATA_W-1:0] win_data,
    output logic              clk_ok,
    output logic              sync_hit
);
    localparam int HALF_W = FRAME_W / 2;
    localparam logic [FRAME_W-1:0] SYNC_PAT =
        {{HALF_W{1'b1}}, {(FRAME_W - HALF_W){1'b0}}};

    logic [FRAME_W-2:0] hist_q;
    logic [FRAME_W-1:0] win;

    // Shift the serial history, newest bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[FRAME_W-3:0], ser_in};
    end

    assign win      = {hist_q, ser_in};
    assign clk_ok   = win[FRAME_W-1] & ~win[0];
    assign sync_hit = (win == SYNC_PAT);

    // Map data bits: first data bit after the leading clock bit is bit 0.
    for (genvar i = 0; i < DATA_W; i++) begin : g_map
        assign win_data[i] = win[FRAME_W-2-i];
    end
endmodule

// File: rtl/ecd_sync_hist.sv
// Module ecd_sync_hist
// Remembers where sync patterns were seen over the last FRAME_W bits and
// flags a pair when a match repeats exactly one frame later. Cleared while
// locked so that a fresh search starts with an empty history.
module ecd_sync_hist #(
    parameter int FRAME_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    output logic pair
);
    logic [FRAME_W-1:0] seen_q;

    // Record match flags, one per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) seen_q <= '0;
        else               seen_q <= {seen_q[FRAME_W-2:0], hit};
    end

    assign pair = hit & seen_q[FRAME_W-1];
endmodule

// File: rtl/ecd_lock_ctrl.sv
// Module ecd_lock_ctrl
// Holds the bit position within the candidate frame, the search state and
// the bad-frame history. Searching locks on a sync pair or after
// ACQ_FRAMES valid frames in a row; an invalid frame shortens the next
// candidate frame by one bit. Locked drops after two bad frames in a row.
module ecd_lock_ctrl
    import ecd_pkg::*;
#(
    parameter int FRAME_W    = 12,
    parameter int ACQ_FRAMES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_ok,
    input  logic sync_pair,
    output logic lock_nxt,
    output logic deliver
);
    localparam int CW = $clog2(FRAME_W);
    localparam int GW = $clog2(ACQ_FRAMES + 1);

    lock_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [GW-1:0] good_q, good_d;
    logic          bad_q, bad_d;
    logic          boundary;

    assign boundary = (cnt_q == CW'(FRAME_W - 1));

    // Next-state decision for alignment, acquisition and loss of lock.
    always_comb begin
        st_d    = st_q;
        cnt_d   = boundary ? '0 : cnt_q + 1'b1;
        good_d  = good_q;
        bad_d   = bad_q;
        deliver = 1'b0;
        case (st_q)
            ST_SEARCH: begin
                if (sync_pair) begin
                    st_d   = ST_LOCKED;
                    cnt_d  = '0;
                    good_d = '0;
                    bad_d  = 1'b0;
                end else if (boundary) begin
                    if (clk_ok) begin
                        if (good_q == GW'(ACQ_FRAMES - 1)) begin
                            st_d   = ST_LOCKED;
                            good_d = '0;
                            bad_d  = 1'b0;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end else begin
                        good_d = '0;
                        cnt_d  = CW'(1);
                    end
                end
            end
            ST_LOCKED: begin
                if (boundary) begin
                    if (!clk_ok && bad_q) begin
                        st_d   = ST_SEARCH;
                        bad_d  = 1'b0;
                        good_d = '0;
                    end else begin
                        deliver = 1'b1;
                        bad_d   = !clk_ok;
                    end
                end
            end
            default: st_d = ST_SEARCH;
        endcase
    end

    // Register the control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_SEARCH;
            cnt_q  <= '0;
            good_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            good_q <= good_d;
            bad_q  <= bad_d;
        end
    end

    assign lock_nxt = (st_d == ST_LOCKED);
endmodule

// File: rtl/ecd_out_stage.sv
// Module ecd_out_stage
// Registers the visible outputs. While unlocked everything is forced high;
// while locked the strobe pulses on each delivered word and the word holds
// between deliveries.
module ecd_out_stage #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_nxt,
    input  logic              deliver,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              lock_n
);
    // Drive outputs from the next lock state and the delivery event.
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_nxt) begin
            word_out <= '1;
            word_stb <= 1'b1;
            lock_n   <= 1'b1;
        end else begin
            lock_n   <= 1'b0;
            word_stb <= deliver;
            if (deliver) word_out <= data;
        end
    end
endmodule

// File: rtl/emb_clk_deser.sv
// Module emb_clk_deser
// Top level of the embedded-clock deserializer. Assumes ser_in is sampled
// on a bit clock already aligned to the line; there is no phase recovery.
module emb_clk_deser #(
    parameter int DATA_W     = 10,
    parameter int ACQ_FRAMES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              lock_n
);
    localparam int FRAME_W = DATA_W + ecd_pkg::CLK_BITS;

    logic [DATA_W-1:0] win_data;
    logic              clk_ok;
    logic              sync_hit;
    logic              sync_pair;
    logic              lock_nxt;
    logic              deliver;

    ecd_window #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .win_data (win_data),
        .clk_ok   (clk_ok),
        .sync_hit (sync_hit)
    );

    ecd_sync_hist #(.FRAME_W(FRAME_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lock_nxt),
        .hit   (sync_hit),
        .pair  (sync_pair)
    );

    ecd_lock_ctrl #(.FRAME_W(FRAME_W), .ACQ_FRAMES(ACQ_FRAMES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_ok    (clk_ok),
        .sync_pair (sync_pair),
        .lock_nxt  (lock_nxt),
        .deliver   (deliver)
    );

    ecd_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_nxt (lock_nxt),
        .deliver  (deliver),
        .data     (win_data),
        .word_out (word_out),
        .word_stb (word_stb),
        .lock_n   (lock_n)
    );
endmodule

// File: rtl/ecd_chk.sv
// Module ecd_chk
// Port-level properties of the deserializer, bound to every instance of
// the top module. Assumes one frame is DATA_W plus two bits long.
module ecd_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_n,
    input logic [DATA_W-1:0] word_out,
    input logic              word_stb
);
    localparam int FRAME_W = DATA_W + ecd_pkg::CLK_BITS;
    localparam int GAP_W   = $clog2(FRAME_W) + 1;

    logic             rst_seen_q = 1'b0;
    logic [GAP_W-1:0] gap_q      = '0;
    logic             gap_ok_q   = 1'b0;

    // Remember that reset was sampled at the previous edge.
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // Count cycles since the last strobe seen while locked.
    always_ff @(posedge clk) begin
        if (!rst_n || lock_n) begin
            gap_q    <= '0;
            gap_ok_q <= 1'b0;
        end else if (word_stb) begin
            gap_q    <= '0;
            gap_ok_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R10
    reset_outputs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen_q |-> (lock_n && word_stb && (&word_out)));

    // R3
    unlocked_outputs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n |-> (word_stb && (&word_out)));

    // R1
    strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_n && word_stb) |=> (lock_n || !word_stb));

    // R1
    strobe_frame_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_n && word_stb && gap_ok_q) |-> (gap_q == GAP_W'(FRAME_W - 1)));

    // R4
    lock_frame_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> !word_stb);
endmodule

bind emb_clk_deser ecd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_n   (lock_n),
    .word_out (word_out),
    .word_stb (word_stb)
);

// File: tb/sim_emb_clk_deser.sv
`timescale 1ns/1ps
// Scoreboard bench: the frame driver queues the words it expects to see
// delivered, and a monitor pops and compares them on each strobe.
module sim_emb_clk_deser;
    localparam logic [9:0] SYNC_W = 10'h01F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic [9:0] word_out;
    logic       word_stb;
    logic       lock_n;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [9:0] exp_q[$];
    logic [15:0] lfsr = 16'hACE1;
    bit         prev_lk_stb = 1'b0;

    emb_clk_deser u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .word_out (word_out),
        .word_stb (word_stb),
        .lock_n   (lock_n)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Random data word with bits 2, 5 and 8 forced high: no run of six zeros,
    // so no sync pattern appears at any offset.
    task automatic rnd_word(output logic [9:0] w);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        w = lfsr[9:0] | 10'h124;
    endtask

    task automatic send_bit(input logic b);
        ser_in = b;
        @(negedge clk);
    endtask

    // mode 0: not delivered, 1: delivered, 2: delivered if locked now
    task automatic send_frame(input logic [9:0] d, input logic sb, input logic eb, input int mode);
        if (mode == 1 || (mode == 2 && lock_n == 1'b0)) exp_q.push_back(d);
        send_bit(sb);
        for (int i = 0; i < 10; i++) send_bit(d[i]);
        send_bit(eb);
    endtask

    task automatic send_rnd(input int mode);
        logic [9:0] w;
        rnd_word(w);
        send_frame(w, 1'b1, 1'b0, mode);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        rst_n = 1'b1;
    endtask

    // Monitor: unlocked outputs, strobe shape and word scoreboard.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (lock_n) begin
                    check(word_stb && (&word_out), "R3 unlocked outputs", {word_stb, word_out}, 11'h7FF);
                    prev_lk_stb = 1'b0;
                end else if (word_stb) begin
                    check(!prev_lk_stb, "R1 strobe longer than one cycle", 1, 0);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R1 unexpected strobe", word_out, 0);
                    end else begin
                        logic [9:0] e;
                        e = exp_q.pop_front();
                        check(word_out == e, "R1 delivered word", word_out, e);
                    end
                    prev_lk_stb = 1'b1;
                end else begin
                    prev_lk_stb = 1'b0;
                end
            end else begin
                prev_lk_stb = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit got;
        logic [9:0] w;

        // Reset state
        do_reset();
        check(lock_n == 1'b1, "R2 lock_n after reset", lock_n, 1);
        check(word_stb && (&word_out), "R10 outputs after reset", {word_stb, word_out}, 11'h7FF);

        // Sync lock from an arbitrary offset
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        send_frame(SYNC_W, 1'b1, 1'b0, 0);
        check(lock_n == 1'b1, "R4 one sync frame must not lock", lock_n, 1);
        send_frame(SYNC_W, 1'b1, 1'b0, 0);
        check(lock_n == 1'b0, "R4 lock after sync pair", lock_n, 0);
        check(word_stb == 1'b0, "R4 lock frame not delivered", word_stb, 0);
        for (int i = 0; i < 4; i++) send_rnd(2);
        send_frame(SYNC_W, 1'b1, 1'b0, 2);

        // Single bad frame keeps lock and is delivered
        rnd_word(w);
        send_frame(w, 1'b0, 1'b0, 1);
        check(lock_n == 1'b0, "R7 single bad frame keeps lock", lock_n, 0);
        send_rnd(2);
        rnd_word(w);
        send_frame(w, 1'b1, 1'b1, 1);
        check(lock_n == 1'b0, "R11 bad-good-bad keeps lock", lock_n, 0);
        send_rnd(2);

        // Two bad frames drop lock
        rnd_word(w);
        send_frame(w, 1'b0, 1'b0, 1);
        rnd_word(w);
        send_frame(w, 1'b0, 1'b1, 0);
        check(lock_n == 1'b1, "R8 lock lost on second bad frame", lock_n, 1);
        check(word_stb && (&word_out), "R8 outputs high after loss", {word_stb, word_out}, 11'h7FF);

        // Relock from sync frames
        send_frame(SYNC_W, 1'b1, 1'b0, 0);
        send_frame(SYNC_W, 1'b1, 1'b0, 0);
        check(lock_n == 1'b0, "R9 relock from sync", lock_n, 0);
        for (int i = 0; i < 3; i++) send_rnd(2);

        // Reset while locked
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(lock_n == 1'b1, "R10 lock_n high in reset", lock_n, 1);
        check(word_stb && (&word_out), "R10 outputs high in reset", {word_stb, word_out}, 11'h7FF);

        // Random-data lock, aligned after reset
        do_reset();
        for (int i = 0; i < 15; i++) send_rnd(0);
        check(lock_n == 1'b1, "R5 no lock after 15 frames", lock_n, 1);
        send_rnd(0);
        check(lock_n == 1'b0, "R5 lock after 16 frames", lock_n, 0);
        check(word_stb == 1'b0, "R5 lock frame not delivered", word_stb, 0);
        for (int i = 0; i < 3; i++) send_rnd(2);

        // Drop, then relock from random data
        rnd_word(w);
        send_frame(w, 1'b0, 1'b0, 1);
        rnd_word(w);
        send_frame(w, 1'b1, 1'b1, 0);
        check(lock_n == 1'b1, "R8 lock lost again", lock_n, 1);
        for (int i = 0; i < 16; i++) send_rnd(0);
        check(lock_n == 1'b0, "R9 relock from random data", lock_n, 0);
        for (int i = 0; i < 2; i++) send_rnd(2);

        // One invalid candidate moves alignment by one bit
        do_reset();
        for (int i = 0; i < 11; i++) send_bit(1'b0);
        for (int i = 0; i < 15; i++) send_rnd(0);
        check(lock_n == 1'b1, "R6 no lock after 15 frames at slipped offset", lock_n, 1);
        send_rnd(0);
        check(lock_n == 1'b0, "R6 lock after one slip and 16 frames", lock_n, 0);
        for (int i = 0; i < 2; i++) send_rnd(2);

        // Search from an arbitrary offset converges
        do_reset();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        got = 1'b0;
        for (int i = 0; i < 200 && !got; i++) begin
            send_rnd(2);
            if (lock_n == 1'b0) got = 1'b1;
        end
        check(got, "R6 search converges from offset 5", got, 1);
        for (int i = 0; i < 5; i++) send_rnd(2);

        @(posedge clk);
        #5;
        @(negedge clk);
        check(exp_q.size() == 0, "R1 all expected words delivered", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule